// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one channel of a direct memory access engine. Software programs a control word, a peripheral base address, a memory base address and a 16-bit transfer count through a small write port. Once the enable bit is set, the channel moves data one element at a time. Each element is one read from the source side followed by one write to the destination side, on a simple request/acknowledge bus. After each element the remaining count drops by one and each side's address advances by its access size, unless increment is off for that side.

In peripheral mode the channel waits for a request line before each element and returns a one-cycle acknowledge when that element has finished. In memory-to-memory mode it runs elements back to back. Normal mode stops when the count reaches zero. Circular mode reloads the programmed count and both base addresses, then keeps running. The channel pulses a half-way event, a completion event and an error event. A bus error also drops the enable bit.

The sequencer has three states. IDLE moves to READ when the channel is enabled, the count is non-zero, and either memory-to-memory mode is set or the request line is high. READ holds a read on the bus. It moves to WRITE on an error-free acknowledge and returns to IDLE on an errored one. WRITE holds a write of the captured data and returns to IDLE on any acknowledge. An error-free acknowledge in WRITE also commits the counter and address update.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the count, both addresses and the control word are zero. The channel is disabled, `bus_req` is low and no event is pulsed.
- R2: A write to the count register (`cfg_sel` = 1) sets both the remaining count and the reload value, but only while the enable bit is clear. A write to the count register while the channel is enabled leaves `remain_cnt` unchanged.
- R3: Each element is one read (`bus_we` = 0) at the source address followed, in the next cycle, by one write (`bus_we` = 1) at the destination address.
  - Control bit 1 selects the direction: 0 makes the peripheral side the source and 1 makes the memory side the source.
  - The written data is the read data masked to the destination size.
- R4: The control word sets how each side's address moves.
  - Control bit 3 enables peripheral-address increment and bit 4 enables memory-address increment.
  - Bits [6:5] give the peripheral size and bits [8:7] give the memory size. Size code 0 is a byte, 1 is a halfword and 2 is a word.
  - An incrementing side steps by 1, 2 or 4 bytes after each element. A side with increment off keeps its base address.
- R5: The remaining count drops by one after each error-free write. In normal mode (control bit 2 clear) it stops at 0, `evt_done` pulses once, and no further bus access starts.
- R6: `evt_half` pulses when the count after an element equals the programmed count divided by two, rounded down.
- R7: In circular mode (control bit 2 set), the element that brings the count to zero reloads the count and returns both addresses to their base values. `evt_done` pulses on every such wrap and transfers continue.
- R8: With control bit 9 set, elements run without a request. With bit 9 clear, each element needs `periph_req` high and ends with a one-cycle `periph_ack`. With no request, no access starts.
- R9: A channel that is enabled with a count of zero issues no bus access.
- R10: An errored acknowledge does three things: it pulses `evt_err`, it clears the enable bit, and it returns the sequencer to IDLE. The count is unchanged, and a read error is never followed by its write.
- R11: Clearing the enable bit (control bit 0) during an element lets that element's read and write complete. No further access then starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 peripheral base, 3 memory base |
| cfg_wdata | input | 32 | Configuration write data |
| periph_req | input | 1 | Peripheral transfer request |
| periph_ack | output | 1 | One-cycle pulse when a requested element has finished |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_err | input | 1 | Error response, valid with `bus_ack` |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| chan_en | output | 1 | Current enable bit |
| remain_cnt | output | 16 | Remaining element count |
| evt_half | output | 1 | Half-way event pulse |
| evt_done | output | 1 | Completion event pulse |
| evt_err | output | 1 | Bus error event pulse |

## Verification
The assertions check on every cycle that:
- a clean read acknowledge is always followed by a write;
- the count changes only by a single decrement, a reload or a permitted write;
- completion in normal mode leaves the count at zero;
- an error event always comes with the channel disabled;
- a disabled or zero-count channel in IDLE never starts an access.

Only the bench scenarios can show the rest:
- the address and data sequences, across every direction, increment and size combination;
- the circular wrap pattern over several rounds;
- the number of half-way and completion events;
- that a count write while enabled has no effect;
- that a disable in mid-element still lets that element finish.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } seq_state_t;

    // control word, bit 0 upward: en, dir, circ, pinc, minc, psize[1:0], msize[1:0], m2m
    typedef struct packed {
        logic       m2m;
        logic [1:0] msize;
        logic [1:0] psize;
        logic       minc;
        logic       pinc;
        logic       circ;
        logic       dir;
        logic       en;
    } chan_ctrl_t;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_PBASE = 2'd2;
    localparam logic [1:0] SEL_MBASE = 2'd3;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    unit_bytes = 3'd1;
            2'd1:    unit_bytes = 3'd2;
            default: unit_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pair_done,
    input  logic              err_hit,
    output chan_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] p_cur,
    output logic [ADDR_W-1:0] m_cur,
    output logic              evt_half,
    output logic              evt_done,
    output logic              evt_err
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    logic [CNT_W-1:0]  reload;
    logic [ADDR_W-1:0] p_base, m_base;
    logic [CNT_W-1:0]  cnt_next;
    logic [ADDR_W-1:0] p_step, m_step;

    always_comb begin
        cnt_next = cnt - CNT_W'(1);
        p_step   = ADDR_W'(unit_bytes(ctrl.psize));
        m_step   = ADDR_W'(unit_bytes(ctrl.msize));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            cnt      <= '0;
            reload   <= '0;
            p_base   <= '0;
            m_base   <= '0;
            p_cur    <= '0;
            m_cur    <= '0;
            evt_half <= 1'b0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
        end else begin
            evt_half <= 1'b0;
            evt_done <= 1'b0;
            evt_err  <= 1'b0;
            if (cfg_we) begin
                unique case (cfg_sel)
                    SEL_CTRL:  ctrl <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    SEL_COUNT: if (!ctrl.en) begin
                        cnt    <= cfg_wdata[CNT_W-1:0];
                        reload <= cfg_wdata[CNT_W-1:0];
                    end
                    SEL_PBASE: begin
                        p_base <= cfg_wdata[ADDR_W-1:0];
                        p_cur  <= cfg_wdata[ADDR_W-1:0];
                    end
                    SEL_MBASE: begin
                        m_base <= cfg_wdata[ADDR_W-1:0];
                        m_cur  <= cfg_wdata[ADDR_W-1:0];
                    end
                endcase
            end
            if (pair_done) begin
                evt_done <= (cnt_next == '0);
                evt_half <= (cnt_next == (reload >> 1));
                if (cnt_next == '0 && ctrl.circ) begin
                    cnt   <= reload;
                    p_cur <= p_base;
                    m_cur <= m_base;
                end else begin
                    cnt <= cnt_next;
                    if (ctrl.pinc) p_cur <= p_cur + p_step;
                    if (ctrl.minc) m_cur <= m_cur + m_step;
                end
            end
            if (err_hit) begin
                ctrl.en <= 1'b0;
                evt_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_ctrl_t        ctrl,
    input  logic              cnt_nz,
    input  logic              periph_req,
    input  logic [ADDR_W-1:0] p_cur,
    input  logic [ADDR_W-1:0] m_cur,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              pair_done,
    output logic              err_hit,
    output logic              periph_ack
);
    seq_state_t        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              start_ok;
    logic [1:0]        dst_size;

    always_comb begin
        start_ok = ctrl.en && cnt_nz && (ctrl.m2m || periph_req);
        state_d  = state_q;
        unique case (state_q)
            S_IDLE:  if (start_ok) state_d = S_READ;
            S_READ:  if (bus_ack)  state_d = bus_err ? S_IDLE : S_WRITE;
            S_WRITE: if (bus_ack)  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_READ && bus_ack && !bus_err) data_q <= bus_rdata;
        end
    end

    always_comb begin
        dst_size   = ctrl.dir ? ctrl.psize : ctrl.msize;
        bus_req    = 1'b0;
        bus_we     = 1'b0;
        bus_addr   = '0;
        bus_size   = 2'd0;
        bus_wdata  = '0;
        pair_done  = 1'b0;
        err_hit    = 1'b0;
        periph_ack = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_READ: begin
                bus_req  = 1'b1;
                bus_addr = ctrl.dir ? m_cur : p_cur;
                bus_size = ctrl.dir ? ctrl.msize : ctrl.psize;
                err_hit  = bus_ack && bus_err;
            end
            S_WRITE: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ctrl.dir ? p_cur : m_cur;
                bus_size = dst_size;
                case (dst_size)
                    2'd0:    bus_wdata = data_q & DATA_W'(8'hFF);
                    2'd1:    bus_wdata = data_q & DATA_W'(16'hFFFF);
                    default: bus_wdata = data_q;
                endcase
                pair_done  = bus_ack && !bus_err;
                err_hit    = bus_ack && bus_err;
                periph_ack = pair_done && !ctrl.m2m;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              chan_en,
    output logic [CNT_W-1:0]  remain_cnt,
    output logic              evt_half,
    output logic              evt_done,
    output logic              evt_err
);
    chan_ctrl_t        ctrl_q;
    logic [ADDR_W-1:0] p_cur, m_cur;
    logic              pair_done, err_hit;

    dmach_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pair_done (pair_done),
        .err_hit   (err_hit),
        .ctrl      (ctrl_q),
        .cnt       (remain_cnt),
        .p_cur     (p_cur),
        .m_cur     (m_cur),
        .evt_half  (evt_half),
        .evt_done  (evt_done),
        .evt_err   (evt_err)
    );

    dmach_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl_q),
        .cnt_nz     (remain_cnt != '0),
        .periph_req (periph_req),
        .p_cur      (p_cur),
        .m_cur      (m_cur),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .pair_done  (pair_done),
        .err_hit    (err_hit),
        .periph_ack (periph_ack)
    );

    assign chan_en = ctrl_q.en;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_sel,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_ack,
    input logic             bus_err,
    input logic             chan_en,
    input logic             circ,
    input logic [CNT_W-1:0] remain_cnt,
    input logic             evt_done,
    input logic             evt_err
);
    logic cnt_wr;
    assign cnt_wr = cfg_we && (cfg_sel == 2'd1);

    assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack && !bus_err) |=> (bus_req && bus_we));

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (remain_cnt != $past(remain_cnt) && !$past(cnt_wr)) |->
        (remain_cnt == $past(remain_cnt) - CNT_W'(1) || evt_done));

    assert_done_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && !circ) |-> (remain_cnt == '0));

    assert_err_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_err |-> !chan_en);

    assert_off_stays_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !$past(chan_en) && !$past(bus_req)) |-> !bus_req);

    assert_zero_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(remain_cnt) == '0 && !$past(bus_req)) |-> !bus_req);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .chan_en    (chan_en),
    .circ       (ctrl_q.circ),
    .remain_cnt (remain_cnt),
    .evt_done   (evt_done),
    .evt_err    (evt_err)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        bus_ack, bus_err;
    logic        chan_en;
    logic [15:0] remain_cnt;
    logic        evt_half, evt_done, evt_err;

    logic        err_arm = 1'b0;
    logic [31:0] err_addr = '0;

    int n_chk = 0;
    int n_bad = 0;
    int wr_n = 0, half_n = 0, done_n = 0, err_n = 0, ack_n = 0, rq_n = 0;
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1357_2468;
    endfunction

    function automatic logic [31:0] sz_mask(input int s);
        return (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic int sz_step(input int s);
        return (s == 0) ? 1 : (s == 1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit en, input bit dir, input bit circ,
                                             input bit pinc, input bit minc, input int psz,
                                             input int msz, input bit m2m);
        return {22'd0, m2m, 2'(msz), 2'(psz), minc, pinc, circ, dir, en};
    endfunction

    assign bus_ack   = bus_req;
    assign bus_rdata = rd_val(bus_addr);
    assign bus_err   = err_arm && bus_req && (bus_addr == err_addr);

    dma_chan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .periph_req(periph_req), .periph_ack(periph_ack), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .chan_en(chan_en), .remain_cnt(remain_cnt),
        .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (bus_req) rq_n++;
            if (bus_req && bus_we && bus_ack && !bus_err) begin
                if (wr_n < 64) begin
                    wa[wr_n] = bus_addr;
                    wd[wr_n] = bus_wdata;
                end
                wr_n++;
            end
            if (evt_half) half_n++;
            if (evt_done) done_n++;
            if (evt_err) err_n++;
            if (periph_ack) ack_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_log();
        wr_n = 0; half_n = 0; done_n = 0; err_n = 0; ack_n = 0; rq_n = 0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_req();
        int old;
        old = ack_n;
        @(negedge clk);
        periph_req = 1'b1;
        for (int k = 0; k < 20 && ack_n == old; k++) @(negedge clk);
        periph_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(remain_cnt == 16'd0, "R1 count", 32'(remain_cnt), 32'd0);
        chk(chan_en == 1'b0, "R1 enable", 32'(chan_en), 32'd0);
        chk(bus_req == 1'b0, "R1 bus idle", 32'(bus_req), 32'd0);
        chk(!evt_half && !evt_done && !evt_err, "R1 events", {29'd0, evt_half, evt_done, evt_err}, 32'd0);

        // R3 R4 R5 R6 R8: sweep direction, increments and sizes, memory-to-memory
        for (int dir = 0; dir < 2; dir++)
        for (int pi = 0; pi < 2; pi++)
        for (int mi = 0; mi < 2; mi++)
        for (int ps = 0; ps < 3; ps++)
        for (int ms = 0; ms < 3; ms++) begin
            int n, ssz, dsz;
            bit sinc, dinc;
            logic [31:0] sb, db, es, ed;
            n = 2 + (idx % 3);
            idx++;
            cfg_write(2'd0, 32'd0);
            cfg_write(2'd2, 32'h0000_1000);
            cfg_write(2'd3, 32'h0000_8000);
            cfg_write(2'd1, 32'(n));
            clear_log();
            cfg_write(2'd0, mk_ctrl(1, dir[0], 0, pi[0], mi[0], ps, ms, 1));
            idle_wait(n * 3 + 6);
            sb   = dir ? 32'h8000 : 32'h1000;
            db   = dir ? 32'h1000 : 32'h8000;
            sinc = dir ? mi[0] : pi[0];
            dinc = dir ? pi[0] : mi[0];
            ssz  = dir ? ms : ps;
            dsz  = dir ? ps : ms;
            chk(wr_n == n, "R5 element count", 32'(wr_n), 32'(n));
            for (int i = 0; i < n; i++) begin
                es = sb + (sinc ? 32'(i * sz_step(ssz)) : 32'd0);
                ed = db + (dinc ? 32'(i * sz_step(dsz)) : 32'd0);
                chk(wa[i] == ed, "R4 write address", wa[i], ed);
                chk(wd[i] == (rd_val(es) & sz_mask(dsz)), "R3 write data", wd[i], rd_val(es) & sz_mask(dsz));
            end
            chk(remain_cnt == 16'd0, "R5 final count", 32'(remain_cnt), 32'd0);
            chk(done_n == 1, "R5 done events", 32'(done_n), 32'd1);
            chk(half_n == 1, "R6 half events", 32'(half_n), 32'd1);
            chk(ack_n == 0, "R8 no ack in m2m", 32'(ack_n), 32'd0);
            cfg_write(2'd0, 32'd0);
        end

        // R2 R8: peripheral-paced, count write while enabled ignored
        cfg_write(2'd2, 32'h0000_0100);
        cfg_write(2'd3, 32'h0000_0200);
        cfg_write(2'd1, 32'd5);
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 0));
        idle_wait(8);
        chk(rq_n == 0, "R8 no access without request", 32'(rq_n), 32'd0);
        cfg_write(2'd1, 32'd9);
        chk(remain_cnt == 16'd5, "R2 count write ignored while enabled", 32'(remain_cnt), 32'd5);
        do_req();
        do_req();
        idle_wait(4);
        chk(wr_n == 2, "R8 one element per request", 32'(wr_n), 32'd2);
        chk(ack_n == 2, "R8 request acknowledges", 32'(ack_n), 32'd2);
        chk(remain_cnt == 16'd3, "R5 count after two", 32'(remain_cnt), 32'd3);
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd7);
        chk(remain_cnt == 16'd7, "R2 count write while disabled", 32'(remain_cnt), 32'd7);

        // R7: circular, peripheral-paced, fixed peripheral word, incrementing memory halfword
        cfg_write(2'd2, 32'h0000_0300);
        cfg_write(2'd3, 32'h0000_0A00);
        cfg_write(2'd1, 32'd4);
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 1, 0, 1, 2, 1, 0));
        for (int i = 0; i < 10; i++) do_req();
        idle_wait(4);
        chk(wr_n == 10, "R7 elements", 32'(wr_n), 32'd10);
        for (int i = 0; i < 10; i++) begin
            chk(wa[i] == 32'h0A00 + 32'(2 * (i % 4)), "R7 wrap address", wa[i], 32'h0A00 + 32'(2 * (i % 4)));
            chk(wd[i] == (rd_val(32'h300) & 32'hFFFF), "R7 data", wd[i], rd_val(32'h300) & 32'hFFFF);
        end
        chk(done_n == 2, "R7 done per wrap", 32'(done_n), 32'd2);
        chk(half_n == 3, "R6 half per round", 32'(half_n), 32'd3);
        chk(remain_cnt == 16'd2, "R7 count after reload", 32'(remain_cnt), 32'd2);
        cfg_write(2'd0, 32'd0);

        // R9: enabled with zero count
        cfg_write(2'd1, 32'd0);
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 1));
        idle_wait(10);
        chk(rq_n == 0, "R9 zero count no access", 32'(rq_n), 32'd0);
        cfg_write(2'd0, 32'd0);

        // R11: disable during the first element
        cfg_write(2'd2, 32'h0000_0100);
        cfg_write(2'd3, 32'h0000_0200);
        cfg_write(2'd1, 32'd8);
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 1));
        cfg_write(2'd0, 32'd0);
        idle_wait(10);
        chk(wr_n == 1, "R11 element finishes then halts", 32'(wr_n), 32'd1);
        chk(remain_cnt == 16'd7, "R11 count", 32'(remain_cnt), 32'd7);
        chk(rq_n == 2, "R11 read and write only", 32'(rq_n), 32'd2);

        // R10: read error on third element
        cfg_write(2'd2, 32'h0000_0400);
        cfg_write(2'd3, 32'h0000_0900);
        cfg_write(2'd1, 32'd5);
        err_addr = 32'h0000_0402;
        err_arm  = 1'b1;
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 1));
        idle_wait(25);
        chk(wr_n == 2, "R10 writes before read error", 32'(wr_n), 32'd2);
        chk(err_n == 1, "R10 error event", 32'(err_n), 32'd1);
        chk(chan_en == 1'b0, "R10 disabled", 32'(chan_en), 32'd0);
        chk(remain_cnt == 16'd3, "R10 count kept", 32'(remain_cnt), 32'd3);

        // R10: write error on first element
        cfg_write(2'd3, 32'h0000_0A00);
        cfg_write(2'd1, 32'd5);
        err_addr = 32'h0000_0A00;
        clear_log();
        cfg_write(2'd0, mk_ctrl(1, 0, 0, 1, 1, 0, 0, 1));
        idle_wait(15);
        chk(wr_n == 0, "R10 no clean write", 32'(wr_n), 32'd0);
        chk(err_n == 1, "R10 write error event", 32'(err_n), 32'd1);
        chk(remain_cnt == 16'd5, "R10 count kept on write error", 32'(remain_cnt), 32'd5);
        chk(rq_n == 2, "R10 stops after error", 32'(rq_n), 32'd2);
        err_arm = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule